// File: doc/BRIEF.md
# Slice-Gated Flit Valid Count Generator

This block tags each eight-element flit entering a vector datapath with the number of leading elements that hold real data, so that a later reduction can skip the padding. A sequencer outside the block supplies, for every flit, one index along the packet dimension and one index for each of three gate dimensions. The slice identifier says which slice is handling the flit. The result is a count from 0 to 8 and a matching element-valid bit vector. The valid elements are always a contiguous prefix of the flit.

The count is built from two kinds of term. The first is a clamped remainder along the packet dimension: the configured valid size minus the packet index, floored at zero and capped by the packet stride. The second is three binary gates. Each gate masks the slice identifier and puts the result in one of three groups relative to a match threshold: below, boundary or above. Below opens the gate. Boundary opens it only while that gate's index is under its valid threshold. For above, a per-gate mode flag decides: it either closes the gate or applies the same test as boundary. The final count is the remainder term when all three gates are open, and zero otherwise.

Flits pass through one register stage with valid/ready handshaking. The flit's data is carried alongside its count and mask.

Top module: `flit_vc_tagger`

## Requirements
- R1: `tagCount` is always in 0..8, and bit p of `tagMask` (bit 0 is element 0) is 1 exactly when p < `tagCount`.
- R2: With every gate open, the count equals min(S, max(0, `cfgPktValid` − `pktIdx`)), where S is `cfgPktStride` with any value above 8 treated as 8. An index at or past the valid size gives 0.
- R3: Gate g masks the slice identifier with bits [g*4 +: 4] of `cfgGateMask`. A masked value strictly below that gate's match threshold (bits [g*4 +: 4] of `cfgGateMatch`) opens the gate for every index.
- R4: A masked value equal to the match threshold opens gate g only while its index (bits [g*8 +: 8] of `gateIdx`) is strictly below its valid threshold (bits [g*8 +: 8] of `cfgGateThresh`).
- R5: In standard mode (bit g of `cfgGateMode` = 0), a masked value above the match threshold closes gate g.
- R6: In transposed mode (bit g of `cfgGateMode` = 1), a masked value above the match threshold gets the same index-versus-threshold test as the boundary group.
- R7: Any closed gate forces the count to 0. Otherwise the packet term passes through unchanged.
- R8: Setting a gate's mask to 0 and match to 1 leaves it open for every slice and index. Mask 0 with match 0 makes it a purely index-based gate.
- R9: For a fixed packet index, the packet term does not depend on the slice identifier.
- R10: A flit accepted on a clock edge (`inValid` and `inReady` both high) appears on the next cycle with `tagValid` high, its count, its mask and its unchanged data.
- R11: While `tagValid` is high and `tagReady` is low, the count, mask and data stay stable, `tagValid` stays high and `inReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input flit valid |
| inReady | output | 1 | Block can accept a flit |
| sliceId | input | 4 | Slice identifier of the flit |
| pktIdx | input | 8 | Packet-dimension index |
| gateIdx | input | 24 | Three gate indices, gate g in bits [g*8 +: 8] |
| inData | input | 64 | Flit data, eight 8-bit elements |
| cfgPktValid | input | 8 | Packet valid size |
| cfgPktStride | input | 4 | Packet stride cap |
| cfgGateMask | input | 12 | Per-gate slice mask, 4 bits each |
| cfgGateMatch | input | 12 | Per-gate match threshold, 4 bits each |
| cfgGateThresh | input | 24 | Per-gate valid threshold, 8 bits each |
| cfgGateMode | input | 3 | Per-gate mode, 1 = transposed |
| tagValid | output | 1 | Output flit valid |
| tagReady | input | 1 | Downstream accepts the flit |
| tagCount | output | 4 | Valid element count, 0..8 |
| tagMask | output | 8 | Contiguous element-valid vector |
| tagData | output | 64 | Flit data |

## Verification
On every cycle, the assertions check four properties. The count stays in range and agrees with the prefix mask. A closed gate zeroes the next count. The count never exceeds the stride cap. The output holds steady under backpressure. Only the bench's scenarios can show the arithmetic itself: the sawtooth of the clamped remainder, the below/boundary/above classification in both modes across full slice-by-index sweeps, the disabled and index-only gate settings, and slice independence. They do this by comparing against counts worked out separately in the bench.

// File: rtl/vcg_pkg.sv
package vcg_pkg;
  typedef struct packed {
    logic load;
  } vcStrobe_t;

  typedef enum logic [1:0] {
    GC_BELOW    = 2'd0,
    GC_BOUNDARY = 2'd1,
    GC_ABOVE    = 2'd2
  } gateClass_t;
endpackage

// File: rtl/vcg_ctrl.sv
module vcg_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  output logic                tagValid,
  input  logic                tagReady,
  output vcg_pkg::vcStrobe_t  strobe
);
  logic validQ;

  assign inReady     = !validQ || tagReady;
  assign strobe.load = inValid && inReady;
  assign tagValid    = validQ;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else if (inReady) validQ <= inValid;
  end

  // R11
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tagValid && !tagReady) |=> tagValid);

  // R11
  no_accept_when_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tagValid && !tagReady) |-> !strobe.load);
endmodule

// File: rtl/vcg_datapath.sv
module vcg_datapath #(
  parameter int SLICE_W = 4,
  parameter int IDX_W   = 8,
  parameter int LANES   = 8,
  parameter int ELEM_W  = 8,
  parameter int GATES   = 3,
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int DATA_W = LANES * ELEM_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  vcg_pkg::vcStrobe_t       strobe,
  input  logic                     tagValid,
  input  logic                     tagReady,
  input  logic [SLICE_W-1:0]       sliceId,
  input  logic [IDX_W-1:0]         pktIdx,
  input  logic [GATES*IDX_W-1:0]   gateIdx,
  input  logic [DATA_W-1:0]        inData,
  input  logic [IDX_W-1:0]         cfgPktValid,
  input  logic [CNT_W-1:0]         cfgPktStride,
  input  logic [GATES*SLICE_W-1:0] cfgGateMask,
  input  logic [GATES*SLICE_W-1:0] cfgGateMatch,
  input  logic [GATES*IDX_W-1:0]   cfgGateThresh,
  input  logic [GATES-1:0]         cfgGateMode,
  output logic [CNT_W-1:0]         tagCount,
  output logic [LANES-1:0]         tagMask,
  output logic [DATA_W-1:0]        tagData
);
  import vcg_pkg::*;

  localparam logic [CNT_W-1:0] LANES_C = CNT_W'(LANES);

  logic [GATES-1:0]  gateOpen;
  logic [CNT_W-1:0]  strideCap;
  logic [IDX_W-1:0]  remain;
  logic [CNT_W-1:0]  pktCount;
  logic [CNT_W-1:0]  nextCount;
  logic [CNT_W-1:0]  countQ;
  logic [DATA_W-1:0] dataQ;

  // Remaining data along the packet dimension; an index at or past the
  // valid size saturates to zero instead of wrapping.
  always_comb begin
    strideCap = (cfgPktStride > LANES_C) ? LANES_C : cfgPktStride;
    remain    = (pktIdx >= cfgPktValid) ? '0 : (cfgPktValid - pktIdx);
    if (remain > IDX_W'(strideCap)) pktCount = strideCap;
    else                            pktCount = CNT_W'(remain);
  end

  for (genvar g = 0; g < GATES; g++) begin : gGate
    logic [SLICE_W-1:0] maskedId;
    logic [SLICE_W-1:0] matchVal;
    logic               idxPass;
    gateClass_t         cls;

    always_comb begin
      maskedId = sliceId & cfgGateMask[g*SLICE_W +: SLICE_W];
      matchVal = cfgGateMatch[g*SLICE_W +: SLICE_W];
      idxPass  = gateIdx[g*IDX_W +: IDX_W] < cfgGateThresh[g*IDX_W +: IDX_W];
      if (maskedId < matchVal)       cls = GC_BELOW;
      else if (maskedId == matchVal) cls = GC_BOUNDARY;
      else                           cls = GC_ABOVE;
      unique case (cls)
        GC_BELOW:    gateOpen[g] = 1'b1;
        GC_BOUNDARY: gateOpen[g] = idxPass;
        GC_ABOVE:    gateOpen[g] = cfgGateMode[g] && idxPass;
        default:     gateOpen[g] = 1'b0;
      endcase
    end
  end

  assign nextCount = (&gateOpen) ? pktCount : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      dataQ  <= '0;
    end else if (strobe.load) begin
      countQ <= nextCount;
      dataQ  <= inData;
    end
  end

  for (genvar p = 0; p < LANES; p++) begin : gLane
    assign tagMask[p] = CNT_W'(p) < countQ;
  end

  assign tagCount = countQ;
  assign tagData  = dataQ;

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tagCount <= LANES_C);

  // R1
  prefix_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($countones(tagMask) == int'(tagCount)) &&
     ((tagMask & (tagMask + 1'b1)) == '0)));

  // R7
  closed_gate_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !(&gateOpen)) |=> (tagCount == '0));

  // R2
  stride_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (tagCount <= $past(cfgPktStride)));

  // R11
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tagValid && !tagReady) |=> ($stable(tagCount) && $stable(tagData)));
endmodule

// File: rtl/flit_vc_tagger.sv
module flit_vc_tagger #(
  parameter int SLICE_W = 4,
  parameter int IDX_W   = 8,
  parameter int LANES   = 8,
  parameter int ELEM_W  = 8,
  parameter int GATES   = 3,
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int DATA_W = LANES * ELEM_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [SLICE_W-1:0]       sliceId,
  input  logic [IDX_W-1:0]         pktIdx,
  input  logic [GATES*IDX_W-1:0]   gateIdx,
  input  logic [DATA_W-1:0]        inData,
  input  logic [IDX_W-1:0]         cfgPktValid,
  input  logic [CNT_W-1:0]         cfgPktStride,
  input  logic [GATES*SLICE_W-1:0] cfgGateMask,
  input  logic [GATES*SLICE_W-1:0] cfgGateMatch,
  input  logic [GATES*IDX_W-1:0]   cfgGateThresh,
  input  logic [GATES-1:0]         cfgGateMode,
  output logic                     tagValid,
  input  logic                     tagReady,
  output logic [CNT_W-1:0]         tagCount,
  output logic [LANES-1:0]         tagMask,
  output logic [DATA_W-1:0]        tagData
);
  vcg_pkg::vcStrobe_t strobe;

  vcg_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .tagValid (tagValid),
    .tagReady (tagReady),
    .strobe   (strobe)
  );

  vcg_datapath #(
    .SLICE_W (SLICE_W),
    .IDX_W   (IDX_W),
    .LANES   (LANES),
    .ELEM_W  (ELEM_W),
    .GATES   (GATES)
  ) datapath_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .tagValid      (tagValid),
    .tagReady      (tagReady),
    .sliceId       (sliceId),
    .pktIdx        (pktIdx),
    .gateIdx       (gateIdx),
    .inData        (inData),
    .cfgPktValid   (cfgPktValid),
    .cfgPktStride  (cfgPktStride),
    .cfgGateMask   (cfgGateMask),
    .cfgGateMatch  (cfgGateMatch),
    .cfgGateThresh (cfgGateThresh),
    .cfgGateMode   (cfgGateMode),
    .tagCount      (tagCount),
    .tagMask       (tagMask),
    .tagData       (tagData)
  );
endmodule

// File: tb/flit_vc_tagger_tb.sv
`timescale 1ns/1ps
module flit_vc_tagger_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [3:0]  sliceId = '0;
  logic [7:0]  pktIdx = '0;
  logic [23:0] gateIdx = '0;
  logic [63:0] inData = '0;
  logic [7:0]  cfgPktValid = '0;
  logic [3:0]  cfgPktStride = '0;
  logic [11:0] cfgGateMask = '0;
  logic [11:0] cfgGateMatch = '0;
  logic [23:0] cfgGateThresh = '0;
  logic [2:0]  cfgGateMode = '0;
  logic        tagValid;
  logic        tagReady = 1'b1;
  logic [3:0]  tagCount;
  logic [7:0]  tagMask;
  logic [63:0] tagData;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  flit_vc_tagger dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .sliceId(sliceId), .pktIdx(pktIdx), .gateIdx(gateIdx), .inData(inData),
    .cfgPktValid(cfgPktValid), .cfgPktStride(cfgPktStride),
    .cfgGateMask(cfgGateMask), .cfgGateMatch(cfgGateMatch),
    .cfgGateThresh(cfgGateThresh), .cfgGateMode(cfgGateMode),
    .tagValid(tagValid), .tagReady(tagReady), .tagCount(tagCount),
    .tagMask(tagMask), .tagData(tagData)
  );

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] prefixOf(int n);
    logic [7:0] m = '0;
    for (int p = 0; p < 8; p++) if (p < n) m[p] = 1'b1;
    return m;
  endfunction

  // Independent model of the count from the requirements
  function automatic int refCount(int s, int pi, int g0, int g1, int g2);
    int rem, cap, pc;
    int gi [3];
    gi[0] = g0; gi[1] = g1; gi[2] = g2;
    rem = int'(cfgPktValid) - pi;
    if (rem < 0) rem = 0;
    cap = (cfgPktStride > 8) ? 8 : int'(cfgPktStride);
    pc = (rem < cap) ? rem : cap;
    for (int g = 0; g < 3; g++) begin
      int m, mt, th;
      bit open;
      m  = s & int'(cfgGateMask[g*4 +: 4]);
      mt = int'(cfgGateMatch[g*4 +: 4]);
      th = int'(cfgGateThresh[g*8 +: 8]);
      if (m < mt)       open = 1;
      else if (m == mt) open = gi[g] < th;
      else              open = cfgGateMode[g] ? (gi[g] < th) : 0;
      if (!open) pc = 0;
    end
    return pc;
  endfunction

  task automatic setGate(int g, int mask, int match, int thr, bit mode);
    cfgGateMask[g*4 +: 4]   = 4'(mask);
    cfgGateMatch[g*4 +: 4]  = 4'(match);
    cfgGateThresh[g*8 +: 8] = 8'(thr);
    cfgGateMode[g]          = mode;
  endtask

  task automatic disableGates();
    for (int g = 0; g < 3; g++) setGate(g, 0, 1, 0, 0);
  endtask

  // Sends one flit with tagReady high, returns the count seen one cycle later
  task automatic sendFlit(int s, int pi, int g0, int g1, int g2, output int cnt);
    logic [63:0] d;
    @(negedge clk);
    d = {s[7:0], pi[7:0], g0[7:0], g1[7:0], g2[7:0], 24'hA5C3E1};
    sliceId = 4'(s); pktIdx = 8'(pi);
    gateIdx = {8'(g2), 8'(g1), 8'(g0)};
    inData = d; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R10 valid", tagValid, 1);
    chk("R10 data", tagData, d);
    chk("R1 mask", tagMask, prefixOf(int'(tagCount)));
    cnt = int'(tagCount);
  endtask

  task automatic checkFlit(string req, int s, int pi, int g0, int g1, int g2, int exp);
    int c;
    sendFlit(s, pi, g0, g1, g2, c);
    chk(req, c, exp);
  endtask

  task automatic testReset();
    chk("R10 reset valid", tagValid, 0);
    chk("R1 reset count", tagCount, 0);
    chk("R11 reset ready", inReady, 1);
  endtask

  task automatic testSawtooth();
    disableGates();
    cfgPktValid = 19; cfgPktStride = 8;
    checkFlit("R2 saw0", 0, 0, 0, 0, 0, 8);
    checkFlit("R2 saw1", 0, 8, 0, 0, 0, 8);
    checkFlit("R2 saw2", 0, 16, 0, 0, 0, 3);
    checkFlit("R2 past end", 0, 24, 0, 0, 0, 0);
    checkFlit("R2 far past", 0, 200, 0, 0, 0, 0);
    cfgPktValid = 11; cfgPktStride = 4;
    checkFlit("R2 cap4 a", 0, 4, 0, 0, 0, 4);
    checkFlit("R2 cap4 b", 0, 8, 0, 0, 0, 3);
    cfgPktValid = 50; cfgPktStride = 15;
    checkFlit("R2 cap over 8", 0, 0, 0, 0, 0, 8);
    checkFlit("R2 partial", 0, 48, 0, 0, 0, 2);
    cfgPktStride = 0;
    checkFlit("R2 zero stride", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic testSliceIndep();
    disableGates();
    cfgPktValid = 19; cfgPktStride = 8;
    for (int s = 0; s < 16; s += 5)
      checkFlit("R9 slice indep", s, 16, 0, 0, 0, 3);
  endtask

  task automatic testStandardHeatmap();
    cfgPktValid = 19; cfgPktStride = 8;
    setGate(0, 4'b0011, 2, 1, 0);
    setGate(1, 4'b1100, 8, 1, 0);
    setGate(2, 0, 1, 0, 0);
    for (int s = 0; s < 16; s++)
      for (int hi = 0; hi < 2; hi++)
        for (int ci = 0; ci < 2; ci++)
          for (int wi = 0; wi < 3; wi++)
            checkFlit("R7 heatmap", s, wi*8, ci, hi, 0, refCount(s, wi*8, ci, hi, 0));
    checkFlit("R4 both boundary", 10, 16, 0, 0, 0, 3);
    checkFlit("R4 boundary over", 2, 0, 1, 0, 0, 0);
    checkFlit("R3 below", 1, 0, 9, 9, 0, 8);
    checkFlit("R5 above closed", 3, 0, 0, 0, 0, 0);
    checkFlit("R5 above h", 12, 0, 0, 0, 0, 0);
  endtask

  task automatic testTransposed();
    cfgPktValid = 8; cfgPktStride = 8;
    setGate(1, 0, 1, 0, 0); setGate(2, 0, 1, 0, 0);
    setGate(0, 4'b0111, 3, 2, 1);
    for (int ho = 0; ho < 8; ho++)
      for (int hi = 0; hi < 3; hi++)
        checkFlit("R6 transposed", ho, 0, hi, 0, 0, ((ho < 3) || (hi < 2)) ? 8 : 0);
    setGate(0, 4'b0111, 3, 2, 0);
    for (int ho = 2; ho < 6; ho++)
      for (int hi = 0; hi < 3; hi++)
        checkFlit("R5 standard", ho, 0, hi, 0, 0,
                  (ho < 3) ? 8 : ((ho == 3 && hi < 2) ? 8 : 0));
  endtask

  task automatic testDisableAndTimeOnly();
    cfgPktValid = 5; cfgPktStride = 8;
    disableGates();
    checkFlit("R8 disabled", 15, 0, 250, 250, 250, 5);
    setGate(2, 0, 0, 3, 0);
    checkFlit("R8 time only open", 15, 0, 0, 0, 2, 5);
    checkFlit("R8 time only closed", 0, 0, 0, 0, 3, 0);
    checkFlit("R8 time only other slice", 7, 0, 0, 0, 3, 0);
  endtask

  task automatic testBackpressure();
    int c;
    logic [63:0] held;
    disableGates();
    cfgPktValid = 19; cfgPktStride = 8;
    @(negedge clk);
    tagReady = 1'b0;
    sliceId = 0; pktIdx = 16; gateIdx = '0; inData = 64'h1111_2222_3333_4444;
    inValid = 1'b1;
    @(negedge clk);
    held = 64'h1111_2222_3333_4444;
    pktIdx = 0; inData = 64'h5555_6666_7777_8888;
    chk("R11 ready low", inReady, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R11 hold valid", tagValid, 1);
    chk("R11 hold count", tagCount, 3);
    chk("R11 hold data", tagData, held);
    chk("R11 ready still low", inReady, 0);
    tagReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R10 second count", tagCount, 8);
    chk("R10 second data", tagData, 64'h5555_6666_7777_8888);
    @(negedge clk);
    chk("R10 drained", tagValid, 0);
    c = 0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    total++; bad++;
    $display("FAIL R10 watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testSawtooth();
    testSliceIndep();
    testStandardHeatmap();
    testTransposed();
    testDisableAndTimeOnly();
    testBackpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule